// File: doc/BRIEF.md
# External Clock Qualifier and Source Switchover

This block decides whether a device may leave its internal oscillator and run from an external synchronization clock. It runs on the internal system clock (20 MHz nominal) and samples the external input through a two-flop synchronizer. It times every rise-to-rise period and both phase widths in system clock cycles. Each period is compared against a window. The nominal centre of that window comes from a 2-bit frequency code, and its width comes from a 2-bit spread-depth code.

A source that keeps producing in-window periods is first debounced and only then flagged valid. After a long changeover delay the select output moves to the external source. The source is rejected at once when its edges stop, when a period falls outside the window, or when either code holds a reserved value. Rejection restarts both timers from zero.

The select output is a level meant for a downstream glitch-free multiplexer. All pins are plain control and status levels. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `ext_clk_qualifier`

## Requirements
- R1: The frequency code selects the nominal input: 0 is 1.1 MHz, 1 is 2.2 MHz and 2 is 4.4 MHz. With the nominal period N = 20000/f_kHz system cycles and tolerance t, a measured rise-to-rise period P is in window when ceil(N*(1-t)) <= P <= floor(N*(1+t)). At 1.1 MHz with ±18% this gives 15..21, and at 2.2 MHz with ±12% it gives 8..10.
- R2: The spread code selects the tolerance: 0 is ±18%, 1 is ±12% and 2 is ±10%. At 1.1 MHz with ±10% the window is 17..20. At 4.4 MHz the window is 4..5 for ±18% and 5..5 for ±10%.
- R3: A high or low phase of a single sampled system cycle is accepted; the minimum phase width is one cycle.
- R4: When the synchronized input shows no edge for 36 system cycles, clk_missing rises. In that same cycle clk_valid and sel_ext are low. clk_missing falls on the next input edge. The first rising edge after a missing condition only serves as a timing reference.
- R5: clk_valid rises 400 system cycles after the first in-window period. Counted from the external rising edge that completes that period, it is first seen between 400 and 406 cycles later.
- R6: sel_ext rises exactly 12000 system cycles after clk_valid rises, and it is never high while clk_valid is low.
- R7: An out-of-window period drops clk_valid and sel_ext on the next cycle without raising clk_missing. Debounce then starts again from the next in-window period.
- R8: A code value of 3 on either code input clears clk_valid and sel_ext on the next cycle and keeps both low for as long as it is present.
- R9: With en low, all three outputs are held low and every counter is cleared.
- R10: After reset, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Detector enable; low clears all state |
| ext_clk_in | input | 1 | External synchronization clock, asynchronous |
| freq_code | input | 2 | Nominal frequency select (3 reserved) |
| spread_code | input | 2 | Tolerance select (3 reserved) |
| clk_valid | output | 1 | External clock qualified after debounce |
| clk_missing | output | 1 | No input edge seen for the missing interval |
| sel_ext | output | 1 | High selects the external clock source |

## Verification
The bench drives periods one cycle inside and one cycle outside each window edge, across several code pairs. A window computed with the wrong rounding would accept 14 or 22 cycles at 1.1 MHz, or reject 15 or 21. The bench measures the exact gap between the rise of clk_valid and the rise of sel_ext. A changeover counter that is off by one shows up there as 11999 or 12001. A short gap in the input, well under the missing interval, must drop the select without raising clk_missing and must restart the debounce. A design that only reacts to missing edges would keep sel_ext high through that gap. The bench also checks that clk_missing stays low 25 cycles after the clock stops, which catches a missing timer that fires early, and that reserved codes and a low enable force every output low.

// File: rtl/ecq_pkg.sv
package ecq_pkg;

  typedef enum logic [1:0] {
    SW_IDLE     = 2'd0,
    SW_DEBOUNCE = 2'd1,
    SW_HOLD     = 2'd2,
    SW_EXTERNAL = 2'd3
  } sw_state_e;

  // convert a time in ns into system cycles, rounding up
  function automatic int ns_to_cyc(input longint ns, input longint sys_khz);
    longint prod;
    prod = ns * sys_khz;
    return int'((prod + 64'd999999) / 64'd1000000);
  endfunction

  // shortest accepted period: ceil(N*(1-t))
  function automatic int win_lo(input int sys_khz, input int f_khz, input int tol_pct);
    longint num;
    longint den;
    num = longint'(sys_khz) * longint'(100 - tol_pct);
    den = longint'(f_khz) * 64'd100;
    return int'((num + den - 64'd1) / den);
  endfunction

  // longest accepted period: floor(N*(1+t))
  function automatic int win_hi(input int sys_khz, input int f_khz, input int tol_pct);
    longint num;
    longint den;
    num = longint'(sys_khz) * longint'(100 + tol_pct);
    den = longint'(f_khz) * 64'd100;
    return int'(num / den);
  endfunction

endpackage

// File: rtl/ecq_sync_edge.sv
module ecq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic async_in,
  output logic s_lvl,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] shreg;
  logic              s_dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      s_dly <= 1'b0;
    end else if (!en) begin
      shreg <= '0;
      s_dly <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-2:0], async_in};
      s_dly <= shreg[STAGES-1];
    end
  end

  assign s_lvl = shreg[STAGES-1];
  assign rise  = s_lvl & ~s_dly;
  assign fall  = ~s_lvl & s_dly;

endmodule

// File: rtl/ecq_period_meter.sv
module ecq_period_meter #(
  parameter int PH_W     = 7,
  parameter int MISS_CYC = 36,
  parameter int MIN_PH   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          s_lvl,
  input  logic          rise,
  input  logic          fall,
  output logic          per_evt,
  output logic [PH_W:0] per_val,
  output logic          ph_ok,
  output logic          miss_evt,
  output logic          missing
);

  localparam int IDLE_W = $clog2(MISS_CYC + 1);
  localparam logic [PH_W-1:0] PH_MAX = '1;

  logic [PH_W-1:0]   hcnt;
  logic [PH_W-1:0]   lcnt;
  logic [IDLE_W-1:0] idle;
  logic              have_ref;
  logic              miss_q;
  logic              edge_any;

  assign edge_any = rise | fall;
  assign miss_evt = !edge_any && !miss_q && (idle == IDLE_W'(MISS_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt     <= '0;
      lcnt     <= '0;
      idle     <= '0;
      have_ref <= 1'b0;
      miss_q   <= 1'b0;
    end else if (!en) begin
      hcnt     <= '0;
      lcnt     <= '0;
      idle     <= '0;
      have_ref <= 1'b0;
      miss_q   <= 1'b0;
    end else begin
      // silence timer
      if (edge_any)     idle <= '0;
      else if (!miss_q) idle <= idle + 1'b1;

      if (edge_any)      miss_q <= 1'b0;
      else if (miss_evt) miss_q <= 1'b1;

      // phase width counters, saturating
      if (rise)                        hcnt <= PH_W'(1);
      else if (s_lvl && hcnt != PH_MAX) hcnt <= hcnt + 1'b1;

      if (fall)                         lcnt <= PH_W'(1);
      else if (!s_lvl && lcnt != PH_MAX) lcnt <= lcnt + 1'b1;

      // first rise after a gap only arms the measurement
      if (miss_evt)  have_ref <= 1'b0;
      else if (rise) have_ref <= 1'b1;
    end
  end

  assign per_evt = rise && have_ref;
  assign per_val = {1'b0, hcnt} + {1'b0, lcnt};
  assign ph_ok   = (hcnt >= PH_W'(MIN_PH)) && (lcnt >= PH_W'(MIN_PH));
  assign missing = miss_q;

endmodule

// File: rtl/ecq_window_sel.sv
module ecq_window_sel
  import ecq_pkg::*;
#(
  parameter int SYS_KHZ  = 20000,
  parameter int BASE_KHZ = 1100,
  parameter int TOL_C0   = 18,
  parameter int TOL_C1   = 12,
  parameter int TOL_C2   = 10,
  parameter int LW       = 8
) (
  input  logic [1:0]    freq_code,
  input  logic [1:0]    spread_code,
  output logic [LW-1:0] lo_lim,
  output logic [LW-1:0] hi_lim,
  output logic          codes_ok
);

  localparam int TOLS [3] = '{TOL_C0, TOL_C1, TOL_C2};

  logic [LW-1:0] lo_tab [4][4];
  logic [LW-1:0] hi_tab [4][4];

  for (genvar fi = 0; fi < 4; fi++) begin : g_freq
    for (genvar ti = 0; ti < 4; ti++) begin : g_tol
      if (fi < 3 && ti < 3) begin : g_calc
        localparam int LO = win_lo(SYS_KHZ, BASE_KHZ << fi, TOLS[ti]);
        localparam int HI = win_hi(SYS_KHZ, BASE_KHZ << fi, TOLS[ti]);
        assign lo_tab[fi][ti] = LW'(LO);
        assign hi_tab[fi][ti] = LW'(HI);
      end else begin : g_rsvd
        assign lo_tab[fi][ti] = '1;
        assign hi_tab[fi][ti] = '0;
      end
    end
  end

  assign codes_ok = (freq_code != 2'd3) && (spread_code != 2'd3);
  assign lo_lim   = lo_tab[freq_code][spread_code];
  assign hi_lim   = hi_tab[freq_code][spread_code];

endmodule

// File: rtl/ecq_switch_ctrl.sv
module ecq_switch_ctrl
  import ecq_pkg::*;
#(
  parameter int DEB_CYC = 400,
  parameter int CHG_CYC = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic good_evt,
  input  logic bad,
  output logic clk_ok,
  output logic use_ext
);

  localparam int T_MAX = (DEB_CYC > CHG_CYC) ? DEB_CYC : CHG_CYC;
  localparam int T_W   = $clog2(T_MAX + 1);

  sw_state_e      st;
  logic [T_W-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SW_IDLE;
      tmr <= '0;
    end else if (!en || bad) begin
      st  <= SW_IDLE;
      tmr <= '0;
    end else begin
      unique case (st)
        SW_IDLE: begin
          tmr <= '0;
          if (good_evt) st <= SW_DEBOUNCE;
        end
        SW_DEBOUNCE: begin
          if (tmr == T_W'(DEB_CYC - 1)) begin
            st  <= SW_HOLD;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        SW_HOLD: begin
          if (tmr == T_W'(CHG_CYC - 1)) begin
            st  <= SW_EXTERNAL;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        SW_EXTERNAL: tmr <= '0;
        default: begin
          st  <= SW_IDLE;
          tmr <= '0;
        end
      endcase
    end
  end

  assign clk_ok  = (st == SW_HOLD) || (st == SW_EXTERNAL);
  assign use_ext = (st == SW_EXTERNAL);

endmodule

// File: rtl/ext_clk_qualifier.sv
module ext_clk_qualifier
  import ecq_pkg::*;
#(
  parameter int SYS_KHZ      = 20000,
  parameter int BASE_KHZ     = 1100,
  parameter int TOL_C0       = 18,
  parameter int TOL_C1       = 12,
  parameter int TOL_C2       = 10,
  parameter int MIN_PHASE_NS = 40,
  parameter int MISS_NS      = 1800,
  parameter int DEBOUNCE_NS  = 20000,
  parameter int SWITCH_NS    = 600000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ext_clk_in,
  input  logic [1:0] freq_code,
  input  logic [1:0] spread_code,
  output logic       clk_valid,
  output logic       clk_missing,
  output logic       sel_ext
);

  localparam int MISS_CYC = ns_to_cyc(MISS_NS, SYS_KHZ);
  localparam int DEB_CYC  = ns_to_cyc(DEBOUNCE_NS, SYS_KHZ);
  localparam int CHG_CYC  = ns_to_cyc(SWITCH_NS, SYS_KHZ);
  localparam int MIN_PH   = (ns_to_cyc(MIN_PHASE_NS, SYS_KHZ) < 1) ? 1
                            : ns_to_cyc(MIN_PHASE_NS, SYS_KHZ);
  localparam int PH_W     = $clog2(MISS_CYC + 1) + 1;
  localparam int LW       = PH_W + 1;

  logic          s_lvl, rise, fall;
  logic          per_evt, ph_ok, miss_evt, missing;
  logic [LW-1:0] per_val, lo_lim, hi_lim;
  logic          codes_ok, in_win, good_evt, bad;

  ecq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .async_in (ext_clk_in),
    .s_lvl    (s_lvl),
    .rise     (rise),
    .fall     (fall)
  );

  ecq_period_meter #(
    .PH_W     (PH_W),
    .MISS_CYC (MISS_CYC),
    .MIN_PH   (MIN_PH)
  ) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .s_lvl    (s_lvl),
    .rise     (rise),
    .fall     (fall),
    .per_evt  (per_evt),
    .per_val  (per_val),
    .ph_ok    (ph_ok),
    .miss_evt (miss_evt),
    .missing  (missing)
  );

  ecq_window_sel #(
    .SYS_KHZ  (SYS_KHZ),
    .BASE_KHZ (BASE_KHZ),
    .TOL_C0   (TOL_C0),
    .TOL_C1   (TOL_C1),
    .TOL_C2   (TOL_C2),
    .LW       (LW)
  ) u_window (
    .freq_code   (freq_code),
    .spread_code (spread_code),
    .lo_lim      (lo_lim),
    .hi_lim      (hi_lim),
    .codes_ok    (codes_ok)
  );

  assign in_win   = (per_val >= lo_lim) && (per_val <= hi_lim) && ph_ok;
  assign good_evt = per_evt && in_win && codes_ok;
  assign bad      = (per_evt && !in_win) || miss_evt || missing || !codes_ok;

  ecq_switch_ctrl #(
    .DEB_CYC (DEB_CYC),
    .CHG_CYC (CHG_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .good_evt (good_evt),
    .bad      (bad),
    .clk_ok   (clk_valid),
    .use_ext  (sel_ext)
  );

  assign clk_missing = missing;

endmodule

// File: rtl/ecq_checker.sv
module ecq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] freq_code,
  input logic [1:0] spread_code,
  input logic       clk_valid,
  input logic       clk_missing,
  input logic       sel_ext
);

  AST_SEL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ext |-> clk_valid); // R6

  AST_SEL_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_ext) |-> $past(clk_valid)); // R6

  AST_MISSING_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_missing |-> (!clk_valid && !sel_ext)); // R4

  AST_VALID_NOT_MISSING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_valid) |-> !clk_missing); // R5

  AST_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_code == 2'd3 || spread_code == 2'd3) |=> (!clk_valid && !sel_ext)); // R8

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!clk_valid && !sel_ext && !clk_missing)); // R9

endmodule

bind ext_clk_qualifier ecq_checker u_ecq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .freq_code   (freq_code),
  .spread_code (spread_code),
  .clk_valid   (clk_valid),
  .clk_missing (clk_missing),
  .sel_ext     (sel_ext)
);

// File: tb/test_ext_clk_qualifier.sv
`timescale 1ns/1ps
module test_ext_clk_qualifier;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       ext_clk_in;
  logic [1:0] freq_code = 2'd0;
  logic [1:0] spread_code = 2'd0;
  logic       clk_valid, clk_missing, sel_ext;

  int n_chk = 0;
  int n_fail = 0;

  // stimulus generator controls
  logic gen_on = 1'b0;
  int   hlen = 9;
  int   llen = 9;
  int   gpos = 0;

  always #10 clk = ~clk;

  ext_clk_qualifier i_ext_clk_qualifier (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .ext_clk_in  (ext_clk_in),
    .freq_code   (freq_code),
    .spread_code (spread_code),
    .clk_valid   (clk_valid),
    .clk_missing (clk_missing),
    .sel_ext     (sel_ext)
  );

  // external clock built from whole system cycles, changed on falling edges
  initial ext_clk_in = 1'b0;
  always @(negedge clk) begin
    if (!gen_on) begin
      ext_clk_in <= 1'b0;
      gpos       <= 0;
    end else begin
      ext_clk_in <= (gpos < hlen);
      gpos       <= (gpos + 1 >= hlen + llen) ? 0 : gpos + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input longint act, input longint lo, input longint hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // R10: reset state, then R4 missing with no clock at all
  task automatic t_reset;
    rst_n = 1'b0; en = 1'b1; gen_on = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    chk("R10 valid", clk_valid, 0);
    chk("R10 missing", clk_missing, 0);
    chk("R10 sel", sel_ext, 0);
    tick(40);
    chk("R4 missing without input", clk_missing, 1);
  endtask

  // R5 debounce window, R6 exact changeover delay
  task automatic t_accept;
    int n;
    int nv;
    freq_code = 2'd0; spread_code = 2'd0; hlen = 9; llen = 9;
    gen_on = 1'b1;
    n = 0;
    while (!clk_valid && n < 3000) begin tick(1); n++; end
    nv = n;
    chk_rng("R5 debounce delay", nv, 18 + 400, 18 + 406);
    chk("R4 missing cleared by edges", clk_missing, 0);
    chk("R6 sel low at valid", sel_ext, 0);
    n = 0;
    while (!sel_ext && n < 13000) begin tick(1); n++; end
    chk("R6 changeover delay", n, 12000);
  endtask

  // R4 missing interval once edges stop
  task automatic t_stop;
    gen_on = 1'b0;
    tick(25);
    chk("R4 missing not early", clk_missing, 0);
    chk("R4 sel held before missing", sel_ext, 1);
    tick(20);
    chk("R4 missing raised", clk_missing, 1);
    chk("R4 valid dropped", clk_valid, 0);
    chk("R4 sel dropped", sel_ext, 0);
  endtask

  task automatic try_period(input string req, input int f, input int s,
                            input int h, input int l, input int exp_ok);
    gen_on = 1'b0;
    tick(60);
    freq_code = 2'(f); spread_code = 2'(s); hlen = h; llen = l;
    gen_on = 1'b1;
    tick(500 + 2 * (h + l));
    chk(req, clk_valid, exp_ok);
    gen_on = 1'b0;
    tick(60);
  endtask

  // R1, R2, R3: window edges
  task automatic t_windows;
    try_period("R1 f0 s0 period 14", 0, 0, 7, 7, 0);
    try_period("R1 f0 s0 period 15", 0, 0, 7, 8, 1);
    try_period("R1 f0 s0 period 21", 0, 0, 10, 11, 1);
    try_period("R1 f0 s0 period 22", 0, 0, 11, 11, 0);
    try_period("R1 f1 s1 period 9", 1, 1, 4, 5, 1);
    try_period("R1 f1 s0 period 11", 1, 0, 5, 6, 0);
    try_period("R2 f0 s2 period 16", 0, 2, 8, 8, 0);
    try_period("R2 f0 s2 period 17", 0, 2, 8, 9, 1);
    try_period("R2 f0 s1 period 16", 0, 1, 8, 8, 1);
    try_period("R2 f2 s0 period 4", 2, 0, 2, 2, 1);
    try_period("R2 f2 s2 period 4", 2, 2, 2, 2, 0);
    try_period("R3 one-cycle high phase", 2, 2, 1, 4, 1);
    try_period("R3 one-cycle low phase", 2, 2, 4, 1, 1);
  endtask

  // R7: short gap gives one long period, not a missing clock
  task automatic t_glitch;
    int n;
    freq_code = 2'd2; spread_code = 2'd2; hlen = 2; llen = 3;
    gen_on = 1'b1;
    n = 0;
    while (!sel_ext && n < 13000) begin tick(1); n++; end
    chk("R7 external selected before gap", sel_ext, 1);
    gen_on = 1'b0;
    tick(15);
    chk("R7 sel held during gap", sel_ext, 1);
    tick(5);
    gen_on = 1'b1;
    tick(10);
    chk("R7 sel dropped", sel_ext, 0);
    chk("R7 valid dropped", clk_valid, 0);
    chk("R7 missing stays low", clk_missing, 0);
    tick(200);
    chk("R7 debounce restarted", clk_valid, 0);
    tick(400);
    chk("R7 valid again", clk_valid, 1);
    chk("R7 sel waits for changeover", sel_ext, 0);
  endtask

  // R8: reserved codes
  task automatic t_code3;
    spread_code = 2'd3;
    tick(2);
    chk("R8 spread 3 clears valid", clk_valid, 0);
    tick(600);
    chk("R8 spread 3 holds valid low", clk_valid, 0);
    chk("R8 spread 3 sel", sel_ext, 0);
    spread_code = 2'd2;
    tick(450);
    chk("R8 recovers with legal code", clk_valid, 1);
    freq_code = 2'd3;
    tick(2);
    chk("R8 freq 3 clears valid", clk_valid, 0);
    tick(500);
    chk("R8 freq 3 holds valid low", clk_valid, 0);
    freq_code = 2'd2;
    tick(450);
    chk("R8 valid before disable", clk_valid, 1);
  endtask

  // R9: enable low
  task automatic t_enable;
    en = 1'b0;
    tick(2);
    chk("R9 valid", clk_valid, 0);
    chk("R9 sel", sel_ext, 0);
    chk("R9 missing", clk_missing, 0);
    gen_on = 1'b0;
    tick(80);
    chk("R9 missing held low", clk_missing, 0);
    en = 1'b1;
    tick(50);
    chk("R9 missing after re-enable", clk_missing, 1);
  endtask

  initial begin
    t_reset();
    t_accept();
    t_stop();
    t_windows();
    t_glitch();
    t_code3();
    t_enable();
    finish_run();
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule